// File: doc/BRIEF.md
# Duty-Cycled Supply Monitor Controller

This block runs a supply-voltage comparator at a low duty cycle so that it costs little power. It drives a 4-bit threshold code and an enable to the analog comparator, which is modelled here as a single input that reads 1 when the supply is below the chosen level. A 3-bit schedule code selects one of three behaviours. The comparator can be kept off, held on for good, or switched on for a single settling cycle once every short, medium or long period of the slow clock. The block takes the comparator's answer only in the cycle after an enable cycle.

A below-threshold answer is a detection. It sets a sticky detection flag, and it can also raise a level interrupt, a one-cycle reset request and a one-cycle wake request. Each of these has its own enable input. The reset and wake actions also leave sticky flags. The flags sit in an 8-bit status word, together with the last answer taken from the comparator. A one-cycle read strobe clears the sticky flags. The threshold and schedule inputs are plain levels, not a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `smon_ctrl`

## Requirements
- R1: After reset, cmp_en, cmp_level, status, irq, reset_req and wake_req are all 0.
- R2: cmp_level takes the value of thresh_code one cycle later. While a periodic sample is in its enable cycle, cmp_level holds its value.
- R3: Schedule codes 0, 5, 6 and 7 leave the comparator off. cmp_en stays low and no answer is taken.
- R4: Code 1 runs the comparator continuously. cmp_en is high from the first cycle after the code is taken, and an answer is taken on every cycle after that.
- R5: Codes 2, 3 and 4 raise cmp_en for exactly one cycle in every PER_S, PER_M and PER_L cycles respectively (defaults 32, 256 and 2048). The first pulse comes P cycles after the code is taken, with cmp_en high in the P-th cycle.
- R6: The value of cmp_below in the cycle after a cmp_en cycle is taken at the end of that cycle. It appears on status bit 6 and stays there until the next answer is taken. No answer is taken in the cmp_en cycle itself.
- R7: A taken answer of 1 sets the detection flag on status bit 5. The flag stays set until it is cleared by a read.
- R8: A one-cycle status_rd clears status bits 2, 4 and 5 at the next edge. If a detection happens in the same cycle, it wins and the flags it drives stay set. Bits 0, 1, 3 and 7 always read 0.
- R9: irq is high exactly while status bit 5 is set and irq_en is 1.
- R10: A detection taken while rst_en is 1 gives a one-cycle reset_req in the next cycle and sets the sticky flag on status bit 4.
- R11: A detection taken while wake_en is 1 gives a one-cycle wake_req in the next cycle and sets the sticky flag on status bit 2.
- R12: Any change of the schedule code restarts the period count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thresh_code | input | TH_W | Threshold level code for the comparator |
| samp_mode | input | 3 | Schedule code |
| irq_en | input | 1 | Enables the interrupt on detection |
| rst_en | input | 1 | Enables the reset request on detection |
| wake_en | input | 1 | Enables the wake request on detection |
| status_rd | input | 1 | Read strobe; clears the sticky flags |
| cmp_below | input | 1 | Comparator output, 1 = supply below threshold |
| cmp_en | output | 1 | Comparator enable |
| cmp_level | output | TH_W | Threshold code held for the comparator |
| status | output | 8 | Status word (bits 2, 4, 5, 6) |
| irq | output | 1 | Interrupt level |
| reset_req | output | 1 | Reset request pulse |
| wake_req | output | 1 | Wake request pulse |

## Verification
The hardest cases to reach from the ports are the ones that need a read strobe or a threshold change to land on the one cycle that matters inside a long period. Examples are a read strobe in the same cycle as a detection, or a threshold change during the enable cycle of a 2048-cycle period. Directed sequences count edges from the moment a schedule code is applied, including a mid-period code change, and so put stimulus on exact cycles of the schedule. A long random run then uses mostly continuous and short-period schedules, so that detections are frequent and collide with strobes and enable changes. Every cycle of that run is compared against a cycle model written from the requirements.

// File: rtl/smon_pkg.sv
package smon_pkg;
  localparam int MODE_W = 3;
  typedef logic [MODE_W-1:0] smode_t;

  localparam smode_t MODE_OFF      = 3'd0;
  localparam smode_t MODE_CONT     = 3'd1;
  localparam int     MODE_PER_BASE = 2;   // codes 2,3,4 are the periodic schedules
  localparam int     NUM_PER       = 3;

  localparam int STAT_W    = 8;
  localparam int ST_WAKE   = 2;
  localparam int ST_RCAUSE = 4;
  localparam int ST_DET    = 5;
  localparam int ST_OUT    = 6;

  // sticky flag slots inside the capture stage
  localparam int FL_DET    = 0;
  localparam int FL_RCAUSE = 1;
  localparam int FL_WAKE   = 2;
  localparam int NUM_FL    = 3;
endpackage

// File: rtl/smon_sched.sv
module smon_sched
  import smon_pkg::*;
#(
  parameter int PER_S = 32,
  parameter int PER_M = 256,
  parameter int PER_L = 2048
) (
  input  logic   clk,
  input  logic   rst_n,
  input  smode_t samp_mode,
  output logic   cmp_en,
  output logic   sample_hold
);
  localparam int PMAX  = (PER_S > PER_M) ? ((PER_S > PER_L) ? PER_S : PER_L)
                                         : ((PER_M > PER_L) ? PER_M : PER_L);
  localparam int CNT_W = $clog2(PMAX);
  localparam int PERS [NUM_PER] = '{PER_S, PER_M, PER_L};

  smode_t             mode_q;
  logic [CNT_W-1:0]   cnt;
  logic [NUM_PER-1:0] sel;
  logic [NUM_PER-1:0] term;
  logic               periodic;
  logic               at_end;
  logic               cont;

  generate
    for (genvar i = 0; i < NUM_PER; i++) begin : g_per
      assign sel[i]  = (mode_q == MODE_W'(MODE_PER_BASE + i));
      assign term[i] = (cnt == CNT_W'(PERS[i] - 1));
    end
  endgenerate

  assign periodic    = |sel;
  assign at_end      = |(sel & term);
  assign cont        = (mode_q == MODE_CONT);
  assign cmp_en      = cont | at_end;
  assign sample_hold = at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      cnt    <= '0;
    end else begin
      mode_q <= samp_mode;
      if (samp_mode != mode_q)  cnt <= '0;
      else if (at_end)          cnt <= '0;
      else if (periodic)        cnt <= cnt + 1'b1;
      else                      cnt <= '0;
    end
  end
endmodule

// File: rtl/smon_level.sv
module smon_level #(
  parameter int TH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold,
  input  logic [TH_W-1:0] thresh_code,
  output logic [TH_W-1:0] cmp_level
);
  always_ff @(posedge clk) begin
    if (!rst_n)     cmp_level <= '0;
    else if (!hold) cmp_level <= thresh_code;
  end
endmodule

// File: rtl/smon_capture.sv
module smon_capture
  import smon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_en,
  input  logic              cmp_below,
  input  logic              status_rd,
  input  logic              irq_en,
  input  logic              rst_en,
  input  logic              wake_en,
  output logic              out_q,
  output logic [NUM_FL-1:0] flags,
  output logic              irq,
  output logic              reset_req,
  output logic              wake_req
);
  logic              en_d;
  logic              hit;
  logic [NUM_FL-1:0] arm;

  assign hit = en_d & cmp_below;
  assign arm[FL_DET]    = 1'b1;
  assign arm[FL_RCAUSE] = rst_en;
  assign arm[FL_WAKE]   = wake_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_d      <= 1'b0;
      out_q     <= 1'b0;
      reset_req <= 1'b0;
      wake_req  <= 1'b0;
    end else begin
      en_d      <= cmp_en;
      if (en_d) out_q <= cmp_below;
      reset_req <= hit & rst_en;
      wake_req  <= hit & wake_en;
    end
  end

  generate
    for (genvar f = 0; f < NUM_FL; f++) begin : g_flag
      always_ff @(posedge clk) begin
        if (!rst_n)                flags[f] <= 1'b0;
        else if (hit && arm[f])    flags[f] <= 1'b1;
        else if (status_rd)        flags[f] <= 1'b0;
      end
    end
  endgenerate

  assign irq = flags[FL_DET] & irq_en;
endmodule

// File: rtl/smon_ctrl.sv
module smon_ctrl
  import smon_pkg::*;
#(
  parameter int TH_W  = 4,
  parameter int PER_S = 32,
  parameter int PER_M = 256,
  parameter int PER_L = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TH_W-1:0]   thresh_code,
  input  logic [MODE_W-1:0] samp_mode,
  input  logic              irq_en,
  input  logic              rst_en,
  input  logic              wake_en,
  input  logic              status_rd,
  input  logic              cmp_below,
  output logic              cmp_en,
  output logic [TH_W-1:0]   cmp_level,
  output logic [STAT_W-1:0] status,
  output logic              irq,
  output logic              reset_req,
  output logic              wake_req
);
  logic              hold;
  logic              out_q;
  logic [NUM_FL-1:0] flags;

  smon_sched #(.PER_S(PER_S), .PER_M(PER_M), .PER_L(PER_L)) u_sched (
    .clk(clk), .rst_n(rst_n), .samp_mode(samp_mode),
    .cmp_en(cmp_en), .sample_hold(hold)
  );

  smon_level #(.TH_W(TH_W)) u_level (
    .clk(clk), .rst_n(rst_n), .hold(hold),
    .thresh_code(thresh_code), .cmp_level(cmp_level)
  );

  smon_capture u_cap (
    .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en), .cmp_below(cmp_below),
    .status_rd(status_rd), .irq_en(irq_en), .rst_en(rst_en), .wake_en(wake_en),
    .out_q(out_q), .flags(flags), .irq(irq),
    .reset_req(reset_req), .wake_req(wake_req)
  );

  always_comb begin
    status            = '0;
    status[ST_WAKE]   = flags[FL_WAKE];
    status[ST_RCAUSE] = flags[FL_RCAUSE];
    status[ST_DET]    = flags[FL_DET];
    status[ST_OUT]    = out_q;
  end
endmodule

// File: rtl/smon_chk.sv
module smon_chk
  import smon_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [MODE_W-1:0] samp_mode,
  input logic              irq_en,
  input logic              rst_en,
  input logic              wake_en,
  input logic              status_rd,
  input logic              cmp_en,
  input logic [STAT_W-1:0] status,
  input logic              irq,
  input logic              reset_req,
  input logic              wake_req
);
  p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((samp_mode == 3'd0 || samp_mode > 3'd4) && $stable(samp_mode)) |-> !cmp_en);

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_mode >= 3'd2 && samp_mode <= 3'd4 && $stable(samp_mode) && cmp_en) |=> !cmp_en);

  p_taken_after_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[ST_DET]) |-> $past(cmp_en, 2));

  p_det_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status[ST_DET] && !status_rd) |=> status[ST_DET]);

  p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  p_rreq_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> (status[ST_RCAUSE] && $past(rst_en)));

  p_wreq_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (status[ST_WAKE] && $past(wake_en)));
endmodule

bind smon_ctrl smon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .samp_mode(samp_mode), .irq_en(irq_en),
  .rst_en(rst_en), .wake_en(wake_en), .status_rd(status_rd),
  .cmp_en(cmp_en), .status(status), .irq(irq),
  .reset_req(reset_req), .wake_req(wake_req)
);

// File: tb/smon_ctrl_bench.sv
module smon_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] thresh_code = '0;
  logic [2:0] samp_mode = '0;
  logic       irq_en = 1'b0, rst_en = 1'b0, wake_en = 1'b0;
  logic       status_rd = 1'b0, cmp_below = 1'b0;
  logic       cmp_en;
  logic [3:0] cmp_level;
  logic [7:0] status;
  logic       irq, reset_req, wake_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit run_cmp = 0;

  always #10 clk = ~clk;

  smon_ctrl u_smon_ctrl (
    .clk(clk), .rst_n(rst_n), .thresh_code(thresh_code), .samp_mode(samp_mode),
    .irq_en(irq_en), .rst_en(rst_en), .wake_en(wake_en), .status_rd(status_rd),
    .cmp_below(cmp_below), .cmp_en(cmp_en), .cmp_level(cmp_level), .status(status),
    .irq(irq), .reset_req(reset_req), .wake_req(wake_req)
  );

  // ---------------- reference model built from the requirements ----------------
  function automatic int per_of(input logic [2:0] m);
    case (m)
      3'd2: return 32;
      3'd3: return 256;
      3'd4: return 2048;
      default: return 0;
    endcase
  endfunction

  logic [2:0] m_mode;
  int         m_cnt;
  logic       m_en_d, m_out, m_det, m_wake, m_rc, m_rreq, m_wreq;
  logic [3:0] m_lvl;

  function automatic logic model_en();
    return (m_mode == 3'd1) || (per_of(m_mode) != 0 && m_cnt == per_of(m_mode) - 1);
  endfunction

  function automatic logic [7:0] model_status();
    logic [7:0] s = '0;
    s[2] = m_wake; s[4] = m_rc; s[5] = m_det; s[6] = m_out;
    return s;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode <= '0; m_cnt <= 0; m_en_d <= 0; m_out <= 0; m_det <= 0;
      m_wake <= 0; m_rc <= 0; m_rreq <= 0; m_wreq <= 0; m_lvl <= '0;
    end else begin
      logic hit, en;
      en  = model_en();
      hit = m_en_d && cmp_below;
      m_mode <= samp_mode;
      if (samp_mode != m_mode) m_cnt <= 0;
      else if (per_of(m_mode) != 0) m_cnt <= (m_cnt == per_of(m_mode) - 1) ? 0 : m_cnt + 1;
      else m_cnt <= 0;
      m_en_d <= en;
      if (!(en && m_mode != 3'd1)) m_lvl <= thresh_code;
      if (m_en_d) m_out <= cmp_below;
      m_det  <= hit | (m_det  & ~status_rd);
      m_wake <= (hit & wake_en) | (m_wake & ~status_rd);
      m_rc   <= (hit & rst_en)  | (m_rc   & ~status_rd);
      m_rreq <= hit & rst_en;
      m_wreq <= hit & wake_en;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (run_cmp && !done) begin
      chk(cmp_en == model_en(), "R5", "cmp_en", cmp_en, model_en());
      chk(cmp_level == m_lvl, "R2", "cmp_level", cmp_level, m_lvl);
      chk(status == model_status(), "R7", "status", status, model_status());
      chk(irq == (m_det & irq_en), "R9", "irq", irq, m_det & irq_en);
      chk(reset_req == m_rreq, "R10", "reset_req", reset_req, m_rreq);
      chk(wake_req == m_wreq, "R11", "wake_req", wake_req, m_wreq);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int highs;
    void'($urandom(32'd20240611));
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk(cmp_en == 0 && status == 0 && irq == 0 && reset_req == 0 && wake_req == 0 && cmp_level == 0,
        "R1", "reset outputs", {cmp_en, status, irq, reset_req, wake_req}, 0);
    run_cmp = 1;

    // R2 threshold follows one cycle later
    thresh_code = 4'd9;
    step(1);
    chk(cmp_level == 4'd9, "R2", "cmp_level", cmp_level, 9);

    // R3 reserved code keeps comparator off
    samp_mode = 3'd6; cmp_below = 1'b1;
    highs = 0;
    for (int i = 0; i < 100; i++) begin step(1); if (cmp_en) highs++; end
    chk(highs == 0, "R3", "cmp_en highs code 6", highs, 0);
    chk(status[5] == 0, "R3", "no detection when off", status[5], 0);
    cmp_below = 1'b0;

    // R5 short period: 4 pulses in 128 cycles
    samp_mode = 3'd2;
    highs = 0;
    for (int i = 0; i < 128; i++) begin step(1); if (cmp_en) highs++; end
    chk(highs == 4, "R5", "pulses in 128 cycles", highs, 4);

    // R12 restart: switch mid-period to the long schedule
    step(10);
    samp_mode = 3'd4;
    step(1);
    step(2046);
    chk(cmp_en == 0, "R12", "cmp_en before first long pulse", cmp_en, 0);
    step(1);
    chk(cmp_en == 1, "R12", "first long pulse", cmp_en, 1);
    step(1);
    chk(cmp_en == 0, "R5", "pulse width one cycle", cmp_en, 0);

    // R4/R6 continuous, answer taken one cycle after enable
    samp_mode = 3'd1; irq_en = 1; rst_en = 1; wake_en = 1;
    step(1);
    chk(cmp_en == 1, "R4", "continuous enable", cmp_en, 1);
    cmp_below = 1'b1;
    step(1);
    chk(status[6] == 0, "R6", "no answer in enable cycle", status[6], 0);
    step(1);
    chk(status[6] == 1 && status[5] == 1, "R6", "answer taken", status, 8'h74);
    chk(reset_req == 1 && status[4] == 1, "R10", "reset request", {reset_req, status[4]}, 2'b11);
    chk(wake_req == 1 && status[2] == 1, "R11", "wake request", {wake_req, status[2]}, 2'b11);
    chk(irq == 1, "R9", "irq level", irq, 1);

    // R8 read in same cycle as detection: detection wins
    status_rd = 1'b1;
    step(1);
    status_rd = 1'b0;
    chk(status[5] == 1, "R8", "detection beats read", status[5], 1);
    cmp_below = 1'b0;
    step(1);
    status_rd = 1'b1;
    step(1);
    status_rd = 1'b0;
    chk((status & 8'h34) == 0, "R8", "read clears sticky bits", status, 0);
    chk(irq == 0, "R9", "irq drops with flag", irq, 0);
    chk(reset_req == 0, "R10", "reset_req single pulse", reset_req, 0);

    // random phase
    for (int i = 0; i < 60000; i++) begin
      if (($urandom % 400) == 0) begin
        int r;
        r = $urandom % 10;
        samp_mode = (r < 4) ? 3'd1 : (r < 7) ? 3'd2 : (r == 7) ? 3'd3 : 3'($urandom % 8);
      end
      cmp_below   = (($urandom % 4) == 0);
      status_rd   = (($urandom % 30) == 0);
      if (($urandom % 50) == 0) thresh_code = 4'($urandom);
      if (($urandom % 100) == 0) irq_en  = ~irq_en;
      if (($urandom % 120) == 0) rst_en  = ~rst_en;
      if (($urandom % 140) == 0) wake_en = ~wake_en;
      step(1);
    end
    finish_run();
  end
endmodule